// File: doc/BRIEF.md
# Configuration Bus Transaction Controller

This block gives a processor a three-register window for running one remote configuration access at a time. The three registers hold the outgoing or returned data word, a command word and a two-flag result word. The command word carries a launch bit, a direction bit and a hierarchical target address made of a DCC index, function code, site, board position and device number. Writing the command word with the launch bit set starts a transaction. The block then presents a valid/ready request to the remote side and waits, with no time limit, for one response carrying read data and an error flag.

Software follows a fixed order. It writes the data word, then writes the result register to clear it, then writes the command word. It then polls until the launch bit reads back as zero and inspects the result flags. While a transaction is in flight, the command and data registers are frozen. A completed read leaves the returned word in the data register.

Top module: `cfg_xact_ctrl`

## Requirements
- R1: After reset, the data, command and result registers read as zero and `link_req_valid_o` is low.
- R2: Byte address 0xA0 reads the data register, 0xA4 the command register and 0xA8 the result register, whose bits 31:2 read zero. Every other address reads zero. Command bits 30:0, including the unused bits 19:18, read back as last accepted.
- R3: Command bit 31 launches. Bit 30 selects write (1) or read (0). Bits 29:26 are the DCC index, 25:20 the function code, 17:16 the site, 15:12 the position and 11:0 the device number. Writing the command with bit 31 set while idle raises `link_req_valid_o` on the next cycle, with these fields and the data register on the request outputs. Bit 31 then reads 1 until the transaction ends.
- R4: The request stays valid with stable fields and data until it is accepted (valid and ready both high). After acceptance, no second request is issued for the same transaction.
- R5: While busy, writes to the command or data register have no effect. In particular, they do not start a new request.
- R6: When the response arrives, on the following cycle bit 31 reads 0 and exactly one result flag is set: bit 0 (complete) when the error input was low, bit 1 (error) when it was high.
- R7: A read that completes without error loads the response data into the data register. A write, or any error, leaves the data register unchanged.
- R8: Any write to the result register clears both flags, and a launch also clears them. A write to the result register while busy does not disturb the running transaction.
- R9: If a result-register write lands in the same cycle as the response, the flags from the response are kept.
- R10: A response presented while no transaction is waiting for one is ignored.
- R11: The sequence data write, result clear, command write with bit 31 set runs a complete transaction.
- R12: Writing the command with bit 31 clear while idle stores it without issuing a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | Access is a write |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| link_req_valid_o | output | 1 | Request valid toward the remote side |
| link_req_ready_i | input | 1 | Remote side accepts the request |
| link_req_write_o | output | 1 | Request direction, 1 = write |
| link_req_dcc_o | output | 4 | DCC index |
| link_req_func_o | output | 6 | Function code |
| link_req_site_o | output | 2 | Site |
| link_req_pos_o | output | 4 | Board position |
| link_req_dev_o | output | 12 | Device number |
| link_req_wdata_o | output | 32 | Outgoing data word |
| link_rsp_valid_i | input | 1 | Response present |
| link_rsp_rdata_i | input | 32 | Response data |
| link_rsp_err_i | input | 1 | Response reports an error |

## Verification
Setting the result flags on a response and clearing them on a software write can land in the same cycle. The bench provokes this by driving a write to 0xA8 in the very cycle the response is presented, for every combination of direction and error. It judges the case by reading back the correct single flag afterwards. It also presents command and data writes during the response wait and confirms they leave neither a second request nor any change in the command or data readback.

// File: rtl/cfg_xact_pkg.sv
package cfg_xact_pkg;
  localparam int unsigned WORD_W = 32;

  localparam int unsigned START_BIT = 31;
  localparam int unsigned WR_BIT    = 30;
  localparam int unsigned DCC_LSB   = 26;
  localparam int unsigned FUNC_LSB  = 20;
  localparam int unsigned SITE_LSB  = 16;
  localparam int unsigned POS_LSB   = 12;
  localparam int unsigned DEV_LSB   = 0;

  localparam int unsigned DCC_W  = 4;
  localparam int unsigned FUNC_W = 6;
  localparam int unsigned SITE_W = 2;
  localparam int unsigned POS_W  = 4;
  localparam int unsigned DEV_W  = 12;

  localparam int unsigned STAT_W = 2;
  localparam int unsigned STAT_DONE_BIT = 0;
  localparam int unsigned STAT_ERR_BIT  = 1;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xact_state_e;

  typedef enum logic [1:0] {
    RS_NONE = 2'd0,
    RS_DATA = 2'd1,
    RS_CTRL = 2'd2,
    RS_STAT = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import cfg_xact_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hA0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hA4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'hA8
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_data_o,
  output logic              wr_ctrl_o,
  output logic              wr_stat_o,
  output rd_sel_e           rd_sel_o
);
  logic hit_data, hit_ctrl, hit_stat, wr_en;

  assign hit_data = (addr_i == DATA_OFS);
  assign hit_ctrl = (addr_i == CTRL_OFS);
  assign hit_stat = (addr_i == STAT_OFS);
  assign wr_en    = sel_i & wr_i;

  assign wr_data_o = wr_en & hit_data;
  assign wr_ctrl_o = wr_en & hit_ctrl;
  assign wr_stat_o = wr_en & hit_stat;

  always_comb begin
    rd_sel_o = RS_NONE;
    if (hit_data)      rd_sel_o = RS_DATA;
    else if (hit_ctrl) rd_sel_o = RS_CTRL;
    else if (hit_stat) rd_sel_o = RS_STAT;
  end
endmodule

// File: rtl/cfg_xact_fsm.sv
module cfg_xact_fsm
  import cfg_xact_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic req_ready_i,
  input  logic rsp_valid_i,
  output logic req_valid_o,
  output logic busy_o,
  output logic done_o
);
  xact_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE: if (launch_i)    state_d = XS_REQ;
      XS_REQ:  if (req_ready_i) state_d = XS_WAIT;
      XS_WAIT: if (rsp_valid_i) state_d = XS_IDLE;
      default:                  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= XS_IDLE;
    else         state_q <= state_d;
  end

  assign req_valid_o = (state_q == XS_REQ);
  assign busy_o      = (state_q != XS_IDLE);
  // responses only count once the request has been taken
  assign done_o      = (state_q == XS_WAIT) & rsp_valid_i;
endmodule

// File: rtl/cfg_status_reg.sv
module cfg_status_reg
  import cfg_xact_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  // completion outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (done_i) begin
      stat_q <= '0;
      stat_q[STAT_ERR_BIT]  <= err_i;
      stat_q[STAT_DONE_BIT] <= ~err_i;
    end else if (clr_i) begin
      stat_q <= '0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/cfg_xact_ctrl.sv
module cfg_xact_ctrl
  import cfg_xact_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'hA0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hA4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'hA8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              link_req_valid_o,
  input  logic              link_req_ready_i,
  output logic              link_req_write_o,
  output logic [3:0]        link_req_dcc_o,
  output logic [5:0]        link_req_func_o,
  output logic [1:0]        link_req_site_o,
  output logic [3:0]        link_req_pos_o,
  output logic [11:0]       link_req_dev_o,
  output logic [31:0]       link_req_wdata_o,
  input  logic              link_rsp_valid_i,
  input  logic [31:0]       link_rsp_rdata_i,
  input  logic              link_rsp_err_i
);
  localparam int unsigned CMD_W = WORD_W - 1;

  logic              wr_data, wr_ctrl, wr_stat;
  rd_sel_e           rd_sel;
  logic              busy, done, launch;
  logic [WORD_W-1:0] data_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] stat_q;

  cfg_reg_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_OFS(DATA_OFS),
    .CTRL_OFS(CTRL_OFS),
    .STAT_OFS(STAT_OFS)
  ) i_decode (
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wr_data_o(wr_data),
    .wr_ctrl_o(wr_ctrl),
    .wr_stat_o(wr_stat),
    .rd_sel_o (rd_sel)
  );

  assign launch = wr_ctrl & ~busy & bus_wdata_i[START_BIT];

  cfg_xact_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .req_ready_i(link_req_ready_i),
    .rsp_valid_i(link_rsp_valid_i),
    .req_valid_o(link_req_valid_o),
    .busy_o     (busy),
    .done_o     (done)
  );

  cfg_status_reg i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_stat | launch),
    .done_i(done),
    .err_i (link_rsp_err_i),
    .stat_o(stat_q)
  );

  // command fields frozen while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cmd_q <= '0;
    else if (wr_ctrl && !busy) cmd_q <= bus_wdata_i[CMD_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (done) begin
      if (!cmd_q[WR_BIT] && !link_rsp_err_i) data_q <= link_rsp_rdata_i;
    end else if (wr_data && !busy) begin
      data_q <= bus_wdata_i;
    end
  end

  always_comb begin
    unique case (rd_sel)
      RS_DATA: bus_rdata_o = data_q;
      RS_CTRL: bus_rdata_o = {busy, cmd_q};
      RS_STAT: bus_rdata_o = {{(WORD_W-STAT_W){1'b0}}, stat_q};
      default: bus_rdata_o = '0;
    endcase
  end

  assign link_req_write_o = cmd_q[WR_BIT];
  assign link_req_dcc_o   = cmd_q[DCC_LSB  +: DCC_W];
  assign link_req_func_o  = cmd_q[FUNC_LSB +: FUNC_W];
  assign link_req_site_o  = cmd_q[SITE_LSB +: SITE_W];
  assign link_req_pos_o   = cmd_q[POS_LSB  +: POS_W];
  assign link_req_dev_o   = cmd_q[DEV_LSB  +: DEV_W];
  assign link_req_wdata_o = data_q;
endmodule

// File: rtl/cfg_xact_chk.sv
module cfg_xact_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy,
  input logic [1:0]  stat,
  input logic        req_valid,
  input logic        req_ready,
  input logic [28:0] req_cmd,
  input logic [31:0] req_wdata
);
  // R6
  start_clr_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (stat != 2'b00));

  // R6
  flag_set_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat != 2'b00) |-> $fell(busy));

  // R6
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat));

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_cmd) && $stable(req_wdata)));

  // R4
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid && req_ready) |=> !req_valid);

  // R3
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid |-> busy);

  // R5
  cmd_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(req_cmd));

  // R8
  launch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (stat == 2'b00));
endmodule

bind cfg_xact_ctrl cfg_xact_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy     (busy),
  .stat     (stat_q),
  .req_valid(link_req_valid_o),
  .req_ready(link_req_ready_i),
  .req_cmd  ({link_req_write_o, link_req_dcc_o, link_req_func_o,
              link_req_site_o, link_req_pos_o, link_req_dev_o}),
  .req_wdata(link_req_wdata_o)
);

// File: tb/test_cfg_xact_ctrl.sv
module test_cfg_xact_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CTRL = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;

  logic        clk, rst_n;
  logic        sel, wr;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        req_valid, req_ready, req_write;
  logic [3:0]  req_dcc, req_pos;
  logic [5:0]  req_func;
  logic [1:0]  req_site;
  logic [11:0] req_dev;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  cfg_xact_ctrl i_cfg_xact_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .link_req_valid_o(req_valid), .link_req_ready_i(req_ready),
    .link_req_write_o(req_write), .link_req_dcc_o(req_dcc),
    .link_req_func_o(req_func), .link_req_site_o(req_site),
    .link_req_pos_o(req_pos), .link_req_dev_o(req_dev),
    .link_req_wdata_o(req_wdata),
    .link_rsp_valid_i(rsp_valid), .link_rsp_rdata_i(rsp_rdata),
    .link_rsp_err_i(rsp_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input int idx, input logic wbit);
    logic [3:0]  dcc  = idx[3:0];
    logic [5:0]  fn   = 6'(idx * 5 + 3);
    logic [1:0]  site = idx[1:0];
    logic [3:0]  pos  = ~idx[3:0];
    logic [11:0] dev  = 12'(idx * 37 + 1);
    return {1'b1, wbit, dcc, fn, idx[1:0] ^ 2'b10, site, pos, dev};
  endfunction

  // one transaction with programmable handshake latencies
  task automatic run_xact(input int idx, input logic wbit, input logic err,
                          input int rl, input int sl, input bit collide, input bit busywr);
    logic [31:0] ctrl, d_out, d_rsp, exp_data, v;
    ctrl  = mk_ctrl(idx, wbit);
    d_out = 32'h1000_0000 + 32'(idx) * 32'h0101_0101;
    d_rsp = ~d_out ^ 32'(idx);
    // R11 documented software order
    bus_wr(A_DATA, d_out);
    bus_wr(A_STAT, 32'h0);
    bus_wr(A_CTRL, ctrl);
    #1;
    check("R3 valid", {31'b0, req_valid}, 32'd1);
    check("R3 fields", {1'b1, req_write, req_dcc, req_func, ctrl[19:18], req_site, req_pos, req_dev}, ctrl);
    check("R3 wdata", req_wdata, d_out);
    for (int k = 0; k < rl; k++) begin
      @(negedge clk); #1;
      check("R4 hold", {31'b0, req_valid}, 32'd1);
    end
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    #1 check("R4 one request", {31'b0, req_valid}, 32'd0);
    if (busywr) begin
      bus_wr(A_CTRL, ~ctrl | 32'h8000_0000);
      bus_wr(A_DATA, 32'hBAD0_0000);
      bus_wr(A_STAT, 32'h0);
      #1 check("R5 no relaunch", {31'b0, req_valid}, 32'd0);
      bus_rd(A_CTRL, v);
      check("R5 ctrl frozen", v, ctrl | 32'h8000_0000);
    end
    for (int k = 0; k < sl; k++) begin
      bus_rd(A_CTRL, v);
      check("R3 start busy", {31'b0, v[31]}, 32'd1);
    end
    @(negedge clk);
    rsp_valid = 1'b1; rsp_err = err; rsp_rdata = d_rsp;
    if (collide) begin
      sel = 1'b1; wr = 1'b1; addr = A_STAT; wdata = 32'h0;
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_err = 1'b0; sel = 1'b0; wr = 1'b0;
    bus_rd(A_STAT, v);
    if (collide) check("R9 flags kept", v, err ? 32'd2 : 32'd1);
    else         check("R6 flags", v, err ? 32'd2 : 32'd1);
    bus_rd(A_CTRL, v);
    check("R6 start clear", v, ctrl & 32'h7FFF_FFFF);
    exp_data = (!wbit && !err) ? d_rsp : d_out;
    bus_rd(A_DATA, v);
    check("R7 data", v, exp_data);
  endtask

  initial begin
    logic [31:0] v;
    sel = 0; wr = 0; addr = 0; wdata = 0;
    req_ready = 0; rsp_valid = 0; rsp_err = 0; rsp_rdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid", {31'b0, req_valid}, 32'd0);
    addr = A_DATA; #1 check("R1 data", rdata, 32'd0);
    addr = A_CTRL; #1 check("R1 ctrl", rdata, 32'd0);
    addr = A_STAT; #1 check("R1 stat", rdata, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 map and unmapped addresses
    bus_wr(A_DATA, 32'hCAFE_F00D);
    bus_rd(A_DATA, v); check("R2 data rb", v, 32'hCAFE_F00D);
    bus_rd(8'h00, v);  check("R2 unmapped 00", v, 32'd0);
    bus_rd(8'hAC, v);  check("R2 unmapped AC", v, 32'd0);
    bus_rd(8'hA2, v);  check("R2 unaligned", v, 32'd0);
    // R12 store without launch
    bus_wr(A_CTRL, 32'h5A5A_5A5A & 32'h7FFF_FFFF);
    #1 check("R12 no request", {31'b0, req_valid}, 32'd0);
    bus_rd(A_CTRL, v); check("R12 ctrl rb", v, 32'h5A5A_5A5A & 32'h7FFF_FFFF);
    bus_rd(A_STAT, v); check("R2 stat idle", v, 32'd0);

    for (int i = 0; i < 36; i++) begin
      run_xact(i, i[0], i[1], (i / 4) % 3, (i / 12) % 3, ((i / 12) % 3) == 1, ((i / 4) % 3) == 2);
    end

    // R8 status write clears flags
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, v); check("R8 clear", v, 32'd0);
    // R8 launch clears flags without software clear
    run_xact(40, 1'b0, 1'b1, 0, 0, 1'b0, 1'b0);
    bus_wr(A_CTRL, mk_ctrl(41, 1'b1));
    bus_rd(A_STAT, v); check("R8 launch clears", v, 32'd0);
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    @(negedge clk); rsp_valid = 1'b1; rsp_err = 1'b0;
    @(negedge clk); rsp_valid = 1'b0;
    bus_rd(A_STAT, v); check("R8 done after", v, 32'd1);

    // R10 stray response while idle
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_DATA, v);
    @(negedge clk); rsp_valid = 1'b1; rsp_err = 1'b1; rsp_rdata = 32'hFFFF_FFFF;
    @(negedge clk); rsp_valid = 1'b0; rsp_err = 1'b0;
    begin
      logic [31:0] v2;
      bus_rd(A_STAT, v2); check("R10 stat", v2, 32'd0);
      bus_rd(A_DATA, v2); check("R10 data", v2, v);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule